// File: doc/BRIEF.md
# Seeded BCD Watchdog Down-Counter

This block is a watchdog timer whose count is kept as four packed BCD digits. The least significant digit is one hundredth of a second, so the timeout can be set anywhere from 0.01 s to 99.99 s. A host reaches the count through two byte-wide registers, selected by `reg_sel`, using single-cycle write and read strobes. A one-cycle `tick` pulse arrives every 10 ms. While counting is enabled and the count is non-zero, each tick takes one hundredth off the count. When the count reaches zero, the block raises a sticky expiry flag. It can also request a reset pulse, which a neighbouring block stretches to the required width.

Every write updates one byte of a seed register and reloads the live count from the seed. Every read captures the whole live count in a snapshot register, which is what the host sees. The read also reloads the live count from the seed. Any access therefore acts as the watchdog's "kick". With counting disabled, the two registers are just 16 bits of storage. A seed of all zeros leaves the watchdog inert even when counting is enabled.

Top module: `bcd_watchdog`

## Requirements
- R1: `reg_sel`=0 addresses the low byte, which holds tenths in bits 7:4 and hundredths in bits 3:0. `reg_sel`=1 addresses the high byte, which holds tens of seconds in bits 7:4 and seconds in bits 3:0. Every digit is written as 0 to 9.
- R2: A write strobe stores `wr_data` into the selected seed byte. At the same clock edge the whole live count is loaded with the updated seed.
- R3: A read strobe latches the full live count as it was before that edge. From the next cycle until the next read strobe, `rd_data` shows the selected byte of that snapshot.
- R4: Any read or write strobe reloads the live count from the seed and takes priority over a tick in the same cycle.
- R5: With `wd_enable`=1 and a non-zero count, each `tick` cycle decrements the count by one in BCD, borrowing across digits and across bytes. The tick that brings the count to zero sets `wf_flag`, visible in the following cycle.
- R6: If `wd_rst_en`=1 at that expiring tick, `rst_req` is high for exactly the one cycle in which `wf_flag` first shows the expiry. If `wd_rst_en`=0, `rst_req` stays low.
- R7: With `wd_enable`=0, ticks leave the count unchanged, and the registers read back exactly what was written.
- R8: An all-zero count with `wd_enable`=1 never sets `wf_flag` and never raises `rst_req`.
- R9: A cycle with `flag_wr_en`=1 and `flag_wr_data`=0 clears `wf_flag`. `flag_wr_data`=1 leaves it unchanged. If expiry and clear fall in the same cycle, the expiry wins.
- R10: After reaching zero, the count stays at zero and gives no further flag or request until an access reloads it.
- R11: While `rst_n` is low at a clock edge, count, seed, snapshot, `wf_flag` and `rst_req` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 10 ms |
| wd_enable | input | 1 | 1: count down; 0: storage only |
| wd_rst_en | input | 1 | 1: expiry also requests a reset pulse |
| reg_sel | input | 1 | Byte select: 0 low (fractions), 1 high (seconds) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data, two BCD digits |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Selected byte of the last read snapshot |
| flag_wr_en | input | 1 | Flag write strobe |
| flag_wr_data | input | 1 | Flag write value; only 0 has an effect |
| wf_flag | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | One-cycle reset pulse request |

## Verification
Every result is registered. A strobe or tick sampled at one rising edge shows its effect on `rd_data`, `wf_flag` and `rst_req` right after that edge. Nothing in the block adds a second cycle of delay. The bench drives inputs on the falling edge. Its reference model applies each sampled input at the rising edge, as integers in hundredths. The bench compares all three outputs at the next falling edge, so every comparison falls exactly one edge after its stimulus. Because reads return the snapshot, multi-digit borrows are observed without stopping the count: the snapshot shows the value before the reload.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the BCD watchdog.
// Assumes one BCD digit is four bits and a register byte holds two digits.
package wdg_pkg;
    localparam int DIGIT_W = 4;
    localparam int BYTE_W  = 8;
    localparam int DIGITS_PER_BYTE = BYTE_W / DIGIT_W;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;
    typedef logic [BYTE_W-1:0]  reg_byte_t;

    localparam bcd_digit_t DIGIT_MAX = 4'd9;
endpackage

// File: rtl/wdg_seed_regs.sv
// Seed register bank: one byte per select value.
// Also gives the seed with a pending write merged in, so the count can be
// reloaded with the new value at the same edge.
// Assumes the select value never exceeds NBYTES-1.
module wdg_seed_regs
    import wdg_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         sel,
    input  reg_byte_t                wr_data,
    output logic [NBYTES*BYTE_W-1:0] seed_next
);
    reg_byte_t seed_q [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Merge a write to this byte into the seed seen by the counter.
        always_comb begin
            seed_next[b*BYTE_W +: BYTE_W] =
                (wr_en && sel == SEL_W'(b)) ? wr_data : seed_q[b];
        end

        // Hold this seed byte.
        always_ff @(posedge clk) begin
            if (!rst_n) seed_q[b] <= '0;
            else        seed_q[b] <= seed_next[b*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/wdg_bcd_counter.sv
// Multi-digit BCD down-counter with a synchronous load.
// The load takes priority over a decrement. A decrement of zero is ignored,
// so the count rests at zero.
// Assumes every loaded digit is 0..9.
module wdg_bcd_counter
    import wdg_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int CNT_W = DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             step;
    logic [DIGITS:0]  borrow;

    // A decrement only acts on a non-zero count and when no load is pending.
    always_comb begin
        step      = dec && !load && (count != '0);
        borrow[0] = step;
        expire    = step && (count == ONE);
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_t cur;
        assign cur = count[g*DIGIT_W +: DIGIT_W];
        // Ripple the borrow through this digit.
        assign borrow[g+1] = borrow[g] && (cur == '0);

        // Update this digit: load, borrow step, or hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                count[g*DIGIT_W +: DIGIT_W] <= '0;
            else if (load)
                count[g*DIGIT_W +: DIGIT_W] <= load_val[g*DIGIT_W +: DIGIT_W];
            else if (borrow[g])
                count[g*DIGIT_W +: DIGIT_W] <= (cur == '0) ? DIGIT_MAX : cur - 1'b1;
        end
    end
endmodule

// File: rtl/wdg_read_latch.sv
// Read snapshot: a read strobe captures the whole live count and the
// selected byte. The output is steady until the next read strobe.
// Assumes the select value never exceeds NBYTES-1.
module wdg_read_latch
    import wdg_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [SEL_W-1:0]         sel,
    input  logic [NBYTES*BYTE_W-1:0] count,
    output reg_byte_t                rd_data
);
    reg_byte_t        snap_q [NBYTES];
    logic [SEL_W-1:0] sel_q;

    // Remember which byte the last read asked for.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (rd_en) sel_q <= sel;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_snap
        // Capture this byte of the live count on a read.
        always_ff @(posedge clk) begin
            if (!rst_n)     snap_q[b] <= '0;
            else if (rd_en) snap_q[b] <= count[b*BYTE_W +: BYTE_W];
        end
    end

    // Present the selected snapshot byte.
    assign rd_data = snap_q[sel_q];
endmodule

// File: rtl/bcd_watchdog.sv
// Seeded BCD watchdog: seed bank, down-counter, read snapshot and sticky flag.
// Any register access reloads the count from the seed. Expiry sets the flag
// and, if enabled, requests a one-cycle reset pulse.
// Assumes tick is a one-cycle pulse and rd_en/wr_en are not both high.
module bcd_watchdog
    import wdg_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int CNT_W  = DIGITS * DIGIT_W,
    localparam int NBYTES = DIGITS / DIGITS_PER_BYTE,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wd_enable,
    input  logic             wd_rst_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic             flag_wr_en,
    input  logic             flag_wr_data,
    output logic             wf_flag,
    output logic             rst_req
);
    logic [CNT_W-1:0] seed_next;
    logic [CNT_W-1:0] count_q;
    logic             access;
    logic             expire;

    assign access = wr_en || rd_en;

    wdg_seed_regs #(.NBYTES(NBYTES)) u_seed (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (reg_sel),
        .wr_data   (wr_data),
        .seed_next (seed_next)
    );

    wdg_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (access),
        .load_val (seed_next),
        .dec      (wd_enable && tick),
        .count    (count_q),
        .expire   (expire)
    );

    wdg_read_latch #(.NBYTES(NBYTES)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (reg_sel),
        .count   (count_q),
        .rd_data (rd_data)
    );

    // Sticky expiry flag: set on expiry, cleared only by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wf_flag <= 1'b0;
        else if (expire)                        wf_flag <= 1'b1;
        else if (flag_wr_en && !flag_wr_data)   wf_flag <= 1'b0;
    end

    // One-cycle reset request at expiry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire && wd_rst_en;
    end
endmodule

// File: rtl/wdg_checker.sv
// Timing properties of the BCD watchdog, attached to every instance of the top.
module wdg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wd_enable,
    input logic             wr_en,
    input logic             rd_en,
    input logic             flag_wr_en,
    input logic             flag_wr_data,
    input logic             wf_flag,
    input logic             rst_req,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R6
    req_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> wf_flag);

    // R6
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    flag_clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wf_flag) |-> $past(flag_wr_en && !flag_wr_data));

    // R8
    flag_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wf_flag) |-> $past(wd_enable && tick && !wr_en && !rd_en && count == ONE));

    // R7
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_enable && !wr_en && !rd_en) |=> $stable(count));

    // R10
    rest_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !wr_en && !rd_en) |=> (count == '0 && !rst_req));
endmodule

bind bcd_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .wd_enable    (wd_enable),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .flag_wr_en   (flag_wr_en),
    .flag_wr_data (flag_wr_data),
    .wf_flag      (wf_flag),
    .rst_req      (rst_req),
    .count        (count_q)
);

// File: tb/bcd_watchdog_tb.sv
// Bench for bcd_watchdog: behavioural model in integer hundredths,
// compared with the outputs on every falling edge.
module bcd_watchdog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wd_enable = 1'b0;
    logic       wd_rst_en = 1'b0;
    logic [0:0] reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       flag_wr_en = 1'b0;
    logic       flag_wr_data = 1'b0;
    logic       wf_flag;
    logic       rst_req;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string tag = "R11";

    // model state, values in hundredths of a second
    int m_cnt = 0, m_seed = 0, m_snap = 0, m_rsel = 0;
    bit m_wf = 0, m_req = 0;

    bcd_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wd_enable(wd_enable),
        .wd_rst_en(wd_rst_en), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .wf_flag(wf_flag), .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    function automatic int bcd2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        bit exp_now;
        exp_now = 0;
        if (!rst_n) begin
            m_cnt = 0; m_seed = 0; m_snap = 0; m_rsel = 0; m_wf = 0; m_req = 0;
        end else begin
            if (wr_en) begin
                if (reg_sel[0]) m_seed = bcd2i(wr_data) * 100 + m_seed % 100;
                else            m_seed = (m_seed / 100) * 100 + bcd2i(wr_data);
                m_cnt = m_seed;
            end else if (rd_en) begin
                m_snap = m_cnt; m_rsel = int'(reg_sel[0]); m_cnt = m_seed;
            end else if (wd_enable && tick && m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) exp_now = 1;
            end
            m_req = exp_now && wd_rst_en;
            if (exp_now) m_wf = 1;
            else if (flag_wr_en && !flag_wr_data) m_wf = 0;
        end
    end

    task automatic cmp(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Compare every output away from the rising edge.
    always @(negedge clk) begin
        int eb;
        cycles++;
        eb = (m_rsel != 0) ? m_snap / 100 : m_snap % 100;
        cmp("rd_data", int'(rd_data), int'(i2bcd(eb)));
        cmp("wf_flag", int'(wf_flag), int'(m_wf));
        cmp("rst_req", int'(rst_req), int'(m_req));
    end

    // Watchdog on the run length.
    always @(negedge clk) begin
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); reg_sel = sel; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(bit sel);
        @(negedge clk); reg_sel = sel; rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic flag_wr(bit v);
        @(negedge clk); flag_wr_data = v; flag_wr_en = 1;
        @(negedge clk); flag_wr_en = 0;
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
            idle(gap);
        end
    endtask

    initial begin
        // R11: reset state, then reads of both bytes return zero
        tag = "R11";
        idle(3);
        @(negedge clk); rst_n = 1;
        rd(1'b0); rd(1'b1); idle(2);

        // R7 and R1: storage-only mode, ticks ignored, bytes read back
        tag = "R7";
        wd_enable = 0;
        wr(1'b0, 8'h34); wr(1'b1, 8'h12);
        ticks(6, 0);
        tag = "R1";
        rd(1'b0); idle(1); rd(1'b1); idle(1);

        // R5 and R6: short count expires, no pulse when wd_rst_en=0
        tag = "R5";
        wr(1'b1, 8'h00); wr(1'b0, 8'h05);
        wd_enable = 1;
        tag = "R6";
        ticks(5, 2);
        // R10: stays at zero, no second flag or request
        tag = "R10";
        ticks(4, 1);
        rd(1'b0); idle(1);

        // R9: writing 1 does nothing, writing 0 clears
        tag = "R9";
        flag_wr(1'b1); idle(2);
        flag_wr(1'b0); idle(2);
        tag = "R10";
        ticks(3, 0); idle(1);

        // R2 and R5: borrow across bytes, with pulse enabled
        tag = "R2";
        wd_enable = 0;
        wr(1'b1, 8'h01); wr(1'b0, 8'h02);
        wd_enable = 1; wd_rst_en = 1;
        tag = "R5";
        ticks(40, 1);
        // R3 and R4: snapshot of the live count, then restart from seed
        tag = "R3";
        rd(1'b0); idle(1);
        tag = "R4";
        ticks(3, 0);
        rd(1'b1); idle(1);
        tag = "R6";
        ticks(102, 0); idle(3);
        flag_wr(1'b0);

        // R8: all-zero seed with counting enabled never expires
        tag = "R8";
        wd_enable = 0;
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        wd_enable = 1;
        ticks(10, 0); idle(2);

        // R4: kicking before expiry postpones it; access beats a same-cycle tick
        tag = "R4";
        wd_enable = 0;
        wr(1'b0, 8'h03);
        wd_enable = 1;
        ticks(2, 1);
        rd(1'b0);
        ticks(2, 1);
        @(negedge clk); tick = 1; wr_en = 1; reg_sel = 1'b0; wr_data = 8'h03;
        @(negedge clk); tick = 0; wr_en = 0;
        ticks(2, 1); idle(2);
        ticks(1, 1); idle(2);
        flag_wr(1'b0);

        // R5: long run across every digit, snapshots of each byte
        tag = "R5";
        wd_enable = 0;
        wr(1'b1, 8'h20); wr(1'b0, 8'h00);
        wd_enable = 1;
        ticks(1437, 0);
        rd(1'b1);
        ticks(999, 0);
        rd(1'b0);
        ticks(2000, 0); idle(3);

        // R9: expiry wins over a same-cycle clear
        tag = "R9";
        flag_wr(1'b0);
        wd_enable = 0; wr(1'b1, 8'h00); wr(1'b0, 8'h01); wd_enable = 1;
        @(negedge clk); tick = 1; flag_wr_en = 1; flag_wr_data = 0;
        @(negedge clk); tick = 0; flag_wr_en = 0;
        idle(3);

        // R11: reset in the middle of a run clears everything
        tag = "R11";
        wr(1'b0, 8'h50);
        ticks(3, 0);
        @(negedge clk); rst_n = 0;
        idle(2);
        @(negedge clk); rst_n = 1;
        rd(1'b0); idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule